// File: doc/BRIEF.md
# RAM-Based Programmable Delay Line

This block delays a data stream by a selectable number of clock cycles, from zero up to sixty-three. The samples are not shifted through a chain of registers. They are written once into a small memory with one write port and one read port, and they stay where they were written. Two address counters move around the memory instead. The write counter stores the current input sample every cycle. The read tap is placed behind the write counter by the selected delay, so the sample it addresses entered exactly that many cycles earlier.

A delay of zero bypasses the memory, and the output then follows the input within the same cycle. After reset the memory holds stale or unknown contents. A two-state fill machine tracks how much valid history has been written, and it forces the output to zero until enough samples exist for the selected delay. Reset puts the machine in FILL. It moves from FILL to FULL on the clock edge that performs the 64th write, and it stays in FULL until the next reset. In FULL, every delay has valid history.

Top module: `ramdelay_line`

## Requirements
- R1: While reset is asserted, and directly after any reset (including one in the middle of a run), the output is zero for every nonzero delay. Samples written before the reset never reach the output.
- R2: When the delay select is 0, the output equals the input in the same cycle, with no clock edge in between.
- R3: For a delay D from 1 to 63, the output in cycle t equals the input of cycle t-D. Cycles are counted from 0, and cycle 0 is the first cycle after reset is released.
- R4: For a nonzero delay D, the output is zero while fewer than D writes have taken place since reset.
- R5: The largest delay, 63, gives the correct sample for as long as the run lasts, including after both address counters have wrapped past the end of the 64-entry memory.
- R6: A change of the delay select takes effect in the same cycle. The output becomes the input from the new delay's number of cycles earlier, provided that much history exists.
- R7: The fill machine goes from FILL to FULL on the 64th write after reset and stays in FULL. From then on, any delay selected gives valid history.
- R8: On reset the read counter is 0 and the write counter is 63 (all ones). Both counters step by one each cycle and wrap to 0, so the write counter always sits one entry behind the read counter. With delay 63, the read tap is the read counter itself, so the first sample written (at entry 63) appears in cycle 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | W (8) | Input sample, written to the memory every cycle |
| dly | input | log2(DEPTH) (6) | Delay in cycles, 0 to 63 |
| dout | output | W (8) | Delayed sample, or zero while the history is too short |

## Verification
A zero delay gives its result combinationally in the same cycle. A nonzero delay D makes a sample visible on the output D rising edges after the cycle in which it was driven, and the fill gating also releases on that edge. The bench drives each new input and delay on the falling edge and compares the output two nanoseconds later, before the next rising edge. It keeps its own per-cycle history of driven samples and indexes it by the cycle count since reset.

// File: rtl/dly_pkg.sv
package dly_pkg;

    // Fill tracking: FILL until every entry has been written once, then FULL.
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/dly_ptr_ctrl.sv
module dly_ptr_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] wr_nx;
    logic [AW-1:0] rd_nx;

    always_comb begin
        wr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        rd_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Write counter starts at the last entry, read counter at the first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= LAST;
            rd_ptr <= '0;
        end else begin
            wr_ptr <= wr_nx;
            rd_ptr <= rd_nx;
        end
    end

endmodule

// File: rtl/dly_fill_fsm.sv
module dly_fill_fsm
    import dly_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output fill_state_e   state,
    output logic [AW-1:0] fill_cnt
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    fill_state_e   state_nx;
    logic [AW-1:0] cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state    <= state_nx;
            fill_cnt <= cnt_nx;
        end
    end

    // Transitions: FILL -> FULL on the write that completes the memory.
    always_comb begin
        state_nx = state;
        cnt_nx   = fill_cnt;
        unique case (state)
            ST_FILL: begin
                if (fill_cnt == LAST) begin
                    state_nx = ST_FULL;
                end else begin
                    cnt_nx = fill_cnt + 1'b1;
                end
            end
            ST_FULL: begin
                state_nx = ST_FULL;
            end
            default: begin
                state_nx = ST_FILL;
            end
        endcase
    end

endmodule

// File: rtl/dly_mem.sv
module dly_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    // One write port, one asynchronous read port; contents are not reset.
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dly_tap.sv
module dly_tap
    import dly_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] dly,
    input  fill_state_e   state,
    input  logic [AW-1:0] fill_cnt,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] raddr,
    output logic [W-1:0]  dout
);

    localparam logic [AW-1:0] SPAN = AW'(DEPTH - 1);
    localparam logic [AW:0]   WRAP = (AW+1)'(DEPTH);

    logic [AW-1:0] back;
    logic [AW:0]   sum;

    // Tap sits (DEPTH-1-dly) entries after the read counter, i.e. dly
    // entries behind the write counter.
    always_comb begin
        back = SPAN - dly;
        sum  = {1'b0, rd_ptr} + {1'b0, back};
        if (sum >= WRAP) begin
            raddr = AW'(sum - WRAP);
        end else begin
            raddr = sum[AW-1:0];
        end
    end

    // Output process
    always_comb begin
        dout = '0;
        unique case (state)
            ST_FILL: begin
                if (dly == '0) begin
                    dout = din;
                end else if (fill_cnt >= dly) begin
                    dout = rdata;
                end else begin
                    dout = '0;
                end
            end
            ST_FULL: begin
                dout = (dly == '0) ? din : rdata;
            end
            default: begin
                dout = '0;
            end
        endcase
    end

endmodule

// File: rtl/ramdelay_line.sv
module ramdelay_line
    import dly_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] dly,
    output logic [W-1:0]  dout
);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] raddr;
    logic [AW-1:0] fill_cnt;
    logic [W-1:0]  rdata;
    fill_state_e   state;

    dly_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr)
    );

    dly_fill_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .fill_cnt (fill_cnt)
    );

    dly_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (1'b1),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    dly_tap #(.W(W), .DEPTH(DEPTH)) u_tap (
        .rd_ptr   (rd_ptr),
        .dly      (dly),
        .state    (state),
        .fill_cnt (fill_cnt),
        .din      (din),
        .rdata    (rdata),
        .raddr    (raddr),
        .dout     (dout)
    );

endmodule

// File: rtl/ramdelay_line_chk.sv
module ramdelay_line_chk
    import dly_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  din,
    input logic [AW-1:0] dly,
    input logic [W-1:0]  dout,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] fill_cnt,
    input fill_state_e   state
);

    // R8: read counter advances by one per cycle with wrap
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_ptr == AW'((int'($past(rd_ptr)) + 1) % DEPTH));

    // R8: write counter is always one entry behind the read counter
    p_ptr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr == AW'((int'(rd_ptr) + DEPTH - 1) % DEPTH));

    // R2: zero delay bypasses the memory
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dly == '0 |-> dout == din);

    // R4: output held at zero while history is too short
    p_fill_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && dly != '0 && fill_cnt < dly) |-> dout == '0);

    // R3: a one-stage delay returns the previous cycle's input
    p_one_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dly == AW'(1) && (state == ST_FULL || fill_cnt != '0)) |-> dout == $past(din));

    // R7: once FULL, the machine stays FULL
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL |=> state == ST_FULL);

endmodule

bind ramdelay_line ramdelay_line_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .dly      (dly),
    .dout     (dout),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .fill_cnt (fill_cnt),
    .state    (state)
);

// File: tb/ramdelay_line_tb_top.sv
`timescale 1ns/1ps
module ramdelay_line_tb_top;

    localparam int W     = 8;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int NSEG  = 8;

    // Stimulus table: delay for each segment and its length in cycles.
    localparam int SEG_DLY [NSEG] = '{5, 0, 1, 17, 63, 2, 40, 63};
    localparam int SEG_LEN [NSEG] = '{20, 6, 8, 30, 80, 10, 20, 70};

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  din;
    logic [AW-1:0] dly;
    logic [W-1:0]  dout;

    int   total;
    int   bad;
    int   t;
    int   prev_d;
    bit   done;
    logic [W-1:0] hist [0:1023];

    ramdelay_line #(.W(W), .DEPTH(DEPTH)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dly   (dly),
        .dout  (dout)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [W-1:0] pat(input int tt, input int seed);
        return W'((tt * 29 + seed * 7 + 3) & 255);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d dly=%0d actual=%0h expected=%0h", tag, t, dly, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the output, step to the next falling edge.
    task automatic step(input int d, input int seed, input string forced);
        logic [W-1:0] v;
        logic [W-1:0] exp;
        string        tag;
        v       = pat(t, seed);
        din     = v;
        dly     = AW'(d);
        hist[t] = v;
        #2;
        if (d == 0)      exp = v;
        else if (t < d)  exp = '0;
        else             exp = hist[t - d];
        if (forced != "")           tag = forced;
        else if (d == 0)            tag = "R2";
        else if (t < d)             tag = "R4";
        else if (d != prev_d)       tag = "R6";
        else if (d == DEPTH - 1)    tag = "R5";
        else                        tag = "R3";
        check(tag, dout, exp);
        prev_d = d;
        @(posedge clk);
        @(negedge clk);
        t++;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total  = 0;
        bad    = 0;
        t      = 0;
        prev_d = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        din    = 8'h5a;
        dly    = AW'(7);
        @(negedge clk);
        @(negedge clk);
        #2;
        check("R1", dout, '0);           // R1: reset, nonzero delay
        dly = '0;
        din = 8'h3c;
        #2;
        check("R1", dout, 8'h3c);        // R1/R2: bypass still direct in reset
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        prev_d = SEG_DLY[0];
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < SEG_LEN[s]; c++) begin
                step(SEG_DLY[s], 1, "");
            end
        end

        // Mid-run reset: stale memory must stay hidden (R1)
        rst_n = 1'b0;
        din   = 8'hff;
        dly   = AW'(5);
        #2;
        check("R1", dout, '0);
        @(negedge clk);
        #2;
        check("R1", dout, '0);
        @(negedge clk);
        rst_n  = 1'b1;
        t      = 0;
        prev_d = 5;
        for (int c = 0; c < 5; c++) begin
            step(5, 2, "R1");            // R1: zeros after reset, no stale data
        end

        // Second reset, maximum delay from the start (R8, R4, R5), then R7
        rst_n = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        t      = 0;
        prev_d = DEPTH - 1;
        for (int c = 0; c < 70; c++) begin
            step(DEPTH - 1, 3, (t == DEPTH - 1) ? "R8" : "");
        end
        step(50, 3, "R7");               // R7: FULL, any delay has history
        step(50, 3, "R7");
        step(0, 3, "");                  // R2
        step(33, 3, "R6");               // R6: immediate retap
        step(33, 3, "");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule